// File: doc/BRIEF.md
# Three-Phase 8-bit Processor Core

This block is a compact 8-bit processor core. It fetches 16-bit instruction words from a memory that has one 8-bit address. It reads data bytes from the low byte of that same memory word and writes data bytes into that low byte. The core holds eight 8-bit registers, selected by a 3-bit code:

| Code | Register |
|------|----------|
| 0 to 3 | general registers G0, G1, G2, G3 |
| 4 | pointer register P0 |
| 5 | pointer register P1 |
| 6 | link register LNK |
| 7 | program counter PC |

The core also holds three flags: carry (CY), zero (Z) and sign (S).

Every instruction takes exactly three clock cycles:

- **Fetch.** The word at PC is requested, and PC+1 is staged in an increment register.
- **Update.** The returned word is captured. The staged increment is written into PC, or into LNK when a call is taken.
- **Execute.** The destination register, the memory or the flags are written.

Jumps are conditional immediate loads into PC. A return is a register move from LNK to PC. The memory is a simple synchronous port that answers one cycle after it sees an address. The arithmetic and logic operations are computed in a separate datapath block.

Top module: `cpu8_core`

## Requirements
- R1: While `rst` is high at a clock edge, PC, every register, every flag and the halted state are cleared on that edge, and the core enters the fetch phase. Right after reset, `mem_rd` is 1, `mem_addr` is 0, `mem_we` is 0 and `halted` is 0.
- R2: Each instruction occupies three cycles, in order: fetch, update, execute. In the fetch cycle `mem_addr` is PC and `mem_rd` is 1. When a program of N executed instructions ends in a halt, `halted` rises 3N clock edges after reset is released.
- R3: An instruction whose high byte is 00010xxx sets `halted`. After that, `halted` stays at 1, `mem_rd` and `mem_we` stay at 0, and no later instruction runs until reset.
- R4: A high byte of 00000xxx or 00001xxx is a no-operation. It changes no register, no flag and no memory.
- R5: MOV (high byte 00011ddd, low byte xsssxxxx) copies register sss into register ddd. Reading code 7 (PC) as a source yields the address of the next instruction. A move from LNK (code 6) into PC acts as a subroutine return.
- R6: LOAD copies the low byte of the memory word into register ddd. The pointer form is 00101ddd / xxxxxaaa and uses register aaa as the address. The absolute form is 00100ddd / address8. The high byte of the memory word is ignored.
- R7: STORE writes register sss into the low byte of a memory word, through a single-cycle `mem_we` pulse in the execute phase. The high byte of the word is left unchanged. The pointer form is 00111sss / xxxxxaaa and the absolute form is 00110sss / address8.
- R8: MOVI (1ccc0ddd / imm8) loads imm8 into ddd only when condition ccc holds. The conditions are: 000 always, 001 Z=1, 010 S=0, 011 CY=1, 100 CY=0, 101 S=1, 110 Z=0. Code 111 never holds.
- R9: JMP is MOVI with ddd=111, so a taken jump loads PC. CALL (1ccc1111 / addr8) does two things when ccc holds: LNK receives the address of the next instruction and PC receives addr8. When ccc fails, neither register changes.
- R10: A high byte of 01bbbddd with bbb≠111 is a binary operation, with low byte ixxxryyy. The first operand is register xxx. The second operand is register yyy when i=0, or the zero-extended value yyy when i=1. The operations are: 000 add with carry, 001 add, 010 subtract with borrow, 011 subtract, 100 AND, 101 OR, 110 XOR. The flags are always updated: CY is the carry or borrow out (0 for the logic operations), Z is set when the result is 0, and S is result bit 7. Register ddd is written only when r=1.
- R11: A high byte of 01111ddd is a unary operation on register sss, with low byte xsssruu0. The operations are: uu=00 invert, with CY=0. uu=01 rotate right, with CY=0. uu=10 shift right with bit 7 set to 0, with CY taking the old bit 0. uu=11 rotate right through carry, where the old CY enters bit 7 and CY takes the old bit 0. Z and S follow the result. Register ddd is written only when r=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Shared memory address |
| mem_rd | output | 1 | Read request; the word arrives on `mem_rdata` one cycle later |
| mem_rdata | input | 16 | Memory word, one cycle after the address |
| mem_we | output | 1 | Write strobe for the low byte of the word at `mem_addr` |
| mem_wdata | output | 8 | Byte to be written |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Each instruction takes three cycles, so `halted` is due exactly 3N clock edges after reset is released. The bench counts edges from the release to that rise and compares the count with the number of instructions the program should execute. A store lands at the edge that closes its execute phase, and a load's data is taken from the memory word one cycle after the update-phase address. For this reason, the bench reads memory contents only after `halted` has risen, when every write is complete. All outputs are sampled one nanosecond after the rising edge, or at the falling edge, so that no sample coincides with an update.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int DATA_W    = 8;
    localparam int INSN_W    = 16;
    localparam int NUM_REGS  = 8;
    localparam int REG_IDX_W = $clog2(NUM_REGS);

    localparam logic [REG_IDX_W-1:0] IDX_LNK = REG_IDX_W'(6);
    localparam logic [REG_IDX_W-1:0] IDX_PC  = REG_IDX_W'(7);

    typedef enum logic [1:0] {
        PH_FETCH,
        PH_UPD,
        PH_EXEC
    } phase_e;

    typedef enum logic [3:0] {
        IC_NOP,
        IC_HALT,
        IC_MOV,
        IC_LDA,
        IC_LDP,
        IC_STA,
        IC_STP,
        IC_ALU,
        IC_MOVI,
        IC_CALL
    } iclass_e;

    typedef struct packed {
        logic cy;
        logic z;
        logic s;
    } flags_t;

    // Map an instruction word to its class.
    function automatic iclass_e classify(input logic [INSN_W-1:0] w);
        iclass_e c;
        if (w[15]) begin
            c = (w[11:8] == 4'hF) ? IC_CALL : IC_MOVI;
        end else if (w[14]) begin
            c = IC_ALU;
        end else begin
            unique case (w[13:11])
                3'b010:  c = IC_HALT;
                3'b011:  c = IC_MOV;
                3'b100:  c = IC_LDA;
                3'b101:  c = IC_LDP;
                3'b110:  c = IC_STA;
                3'b111:  c = IC_STP;
                default: c = IC_NOP;
            endcase
        end
        return c;
    endfunction

    // Evaluate a 3-bit condition code against the current flags.
    function automatic logic cond_ok(input logic [2:0] c, input flags_t f);
        logic r;
        unique case (c)
            3'b000:  r = 1'b1;
            3'b001:  r = f.z;
            3'b010:  r = ~f.s;
            3'b011:  r = f.cy;
            3'b100:  r = ~f.cy;
            3'b101:  r = f.s;
            3'b110:  r = ~f.z;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [2:0]   op,
    input  logic [1:0]   uop,
    input  logic         cy_in,
    output logic [W-1:0] res,
    output flags_t       flg
);

    logic [W:0] wide;
    logic       cy;

    always_comb begin
        wide = '0;
        res  = '0;
        cy   = 1'b0;
        unique case (op)
            3'b000: begin
                wide = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cy_in};
                res  = wide[W-1:0];
                cy   = wide[W];
            end
            3'b001: begin
                wide = {1'b0, opa} + {1'b0, opb};
                res  = wide[W-1:0];
                cy   = wide[W];
            end
            3'b010: begin
                wide = {1'b0, opa} - {1'b0, opb} - {{W{1'b0}}, cy_in};
                res  = wide[W-1:0];
                cy   = wide[W];
            end
            3'b011: begin
                wide = {1'b0, opa} - {1'b0, opb};
                res  = wide[W-1:0];
                cy   = wide[W];
            end
            3'b100: res = opa & opb;
            3'b101: res = opa | opb;
            3'b110: res = opa ^ opb;
            default: begin
                unique case (uop)
                    2'b00: res = ~opa;
                    2'b01: res = {opa[0], opa[W-1:1]};
                    2'b10: begin
                        res = {1'b0, opa[W-1:1]};
                        cy  = opa[0];
                    end
                    default: begin
                        res = {cy_in, opa[W-1:1]};
                        cy  = opa[0];
                    end
                endcase
            end
        endcase
        flg.cy = cy;
        flg.z  = (res == '0);
        flg.s  = res[W-1];
    end

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
    import cpu8_pkg::*;
#(
    parameter int N    = NUM_REGS,
    parameter int W    = DATA_W,
    localparam int IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb,
    output logic [W-1:0]  pc
);

    logic [N-1:0][W-1:0] regs;

    always_ff @(posedge clk) begin
        for (int g = 0; g < N; g++) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (widx == IW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign ra = regs[ra_idx];
    assign rb = regs[rb_idx];
    assign pc = regs[N-1];

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [INSN_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              halted
);

    phase_e                 phase_q;
    flags_t                 flags_q;
    logic [DATA_W-1:0]      inc_q;
    logic [INSN_W-1:0]      ir_q;
    logic                   halted_q;

    logic [INSN_W-1:0]      word;
    iclass_e                cls;
    logic                   hit;

    logic [REG_IDX_W-1:0]   ra_idx;
    logic [REG_IDX_W-1:0]   rb_idx;
    logic [DATA_W-1:0]      ra_raw;
    logic [DATA_W-1:0]      rb_raw;
    logic [DATA_W-1:0]      opa;
    logic [DATA_W-1:0]      opb;
    logic [DATA_W-1:0]      pc_val;

    logic [DATA_W-1:0]      alu_b;
    logic [DATA_W-1:0]      alu_res;
    flags_t                 alu_flg;

    logic                   rf_we;
    logic [REG_IDX_W-1:0]   rf_idx;
    logic [DATA_W-1:0]      rf_wd;

    // In the update phase the word is taken straight from memory;
    // afterwards it comes from the captured copy.
    assign word = (phase_q == PH_UPD) ? mem_rdata : ir_q;
    assign cls  = classify(word);
    assign hit  = cond_ok(word[14:12], flags_q);

    always_comb begin
        rb_idx = word[2:0];
        if (cls == IC_STA || cls == IC_STP) begin
            ra_idx = word[10:8];
        end else if (phase_q == PH_UPD) begin
            ra_idx = word[2:0];
        end else begin
            ra_idx = word[6:4];
        end
    end

    cpu8_regfile #(
        .N (NUM_REGS),
        .W (DATA_W)
    ) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .widx   (rf_idx),
        .wdata  (rf_wd),
        .ra_idx (ra_idx),
        .ra     (ra_raw),
        .rb_idx (rb_idx),
        .rb     (rb_raw),
        .pc     (pc_val)
    );

    // Reading the program counter yields the address of the next instruction.
    assign opa   = (ra_idx == IDX_PC) ? inc_q : ra_raw;
    assign opb   = (rb_idx == IDX_PC) ? inc_q : rb_raw;
    assign alu_b = word[7] ? {{(DATA_W-3){1'b0}}, word[2:0]} : opb;

    cpu8_alu #(
        .W (DATA_W)
    ) u_alu (
        .opa   (opa),
        .opb   (alu_b),
        .op    (word[13:11]),
        .uop   (word[2:1]),
        .cy_in (flags_q.cy),
        .res   (alu_res),
        .flg   (alu_flg)
    );

    // Single register write port, time-shared between update and execute.
    always_comb begin
        rf_we  = 1'b0;
        rf_idx = word[10:8];
        rf_wd  = opa;
        if (!halted_q) begin
            unique case (phase_q)
                PH_UPD: begin
                    rf_we  = 1'b1;
                    rf_idx = (cls == IC_CALL && hit) ? IDX_LNK : IDX_PC;
                    rf_wd  = inc_q;
                end
                PH_EXEC: begin
                    unique case (cls)
                        IC_MOV: rf_we = 1'b1;
                        IC_MOVI: begin
                            rf_we = hit;
                            rf_wd = word[7:0];
                        end
                        IC_CALL: begin
                            rf_we  = hit;
                            rf_idx = IDX_PC;
                            rf_wd  = word[7:0];
                        end
                        IC_LDA, IC_LDP: begin
                            rf_we = 1'b1;
                            rf_wd = mem_rdata[DATA_W-1:0];
                        end
                        IC_ALU: begin
                            rf_we = word[3];
                            rf_wd = alu_res;
                        end
                        default: rf_we = 1'b0;
                    endcase
                end
                default: rf_we = 1'b0;
            endcase
        end
    end

    // Memory port
    always_comb begin
        mem_addr  = pc_val;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = opa;
        if (!halted_q) begin
            unique case (phase_q)
                PH_FETCH: mem_rd = 1'b1;
                PH_UPD: begin
                    if (cls == IC_LDA) begin
                        mem_rd   = 1'b1;
                        mem_addr = word[7:0];
                    end else if (cls == IC_LDP) begin
                        mem_rd   = 1'b1;
                        mem_addr = opa;
                    end
                end
                PH_EXEC: begin
                    if (cls == IC_STA) begin
                        mem_we   = 1'b1;
                        mem_addr = word[7:0];
                    end else if (cls == IC_STP) begin
                        mem_we   = 1'b1;
                        mem_addr = opb;
                    end
                end
                default: mem_rd = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_FETCH;
            flags_q  <= '0;
            inc_q    <= '0;
            ir_q     <= '0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            unique case (phase_q)
                PH_FETCH: begin
                    inc_q   <= pc_val + 1'b1;
                    phase_q <= PH_UPD;
                end
                PH_UPD: begin
                    ir_q    <= mem_rdata;
                    phase_q <= PH_EXEC;
                end
                default: begin
                    phase_q <= PH_FETCH;
                    if (cls == IC_ALU)  flags_q  <= alu_flg;
                    if (cls == IC_HALT) halted_q <= 1'b1;
                end
            endcase
        end
    end

    assign halted = halted_q;

    // R1: reset leaves a cleared, running core in fetch
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc_val == '0 && !halted_q && phase_q == PH_FETCH && flags_q == '0));

    // R2: phase ordering
    a_r2_fetch_to_upd: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH && !halted_q) |=> (phase_q == PH_UPD));

    a_r2_upd_to_exec: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_UPD) |=> (phase_q == PH_EXEC));

    // R2: the staged increment is the fetched address plus one
    a_r2_inc_staged: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_UPD) |-> (inc_q == $past(pc_val) + 8'd1));

    // R9: outside a call, the update phase advances PC to the staged value
    a_r9_pc_advances: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_UPD && cls != IC_CALL) |=> (pc_val == $past(inc_q)));

    // R3: halt is sticky and quiet
    a_r3_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> halted_q);

    a_r3_quiet_halt: assert property (@(posedge clk) disable iff (rst)
        halted_q |-> (!mem_rd && !mem_we));

    // R7: writes only occur in execute
    a_r7_store_in_exec: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase_q == PH_EXEC));

    // R10: logic operations leave carry clear
    a_r10_logic_clears_cy: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && cls == IC_ALU && word[13] && word[13:11] != 3'b111)
        |=> !flags_q.cy);

endmodule

// File: tb/cpu8_core_tb.sv
`timescale 1ns/1ps
module cpu8_core_tb_top;

    localparam logic [2:0] G0 = 3'd0, G1 = 3'd1, G2 = 3'd2, G3 = 3'd3;
    localparam logic [2:0] P0 = 3'd4, P1 = 3'd5, LNK = 3'd6, PCR = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        halted;

    logic [15:0] mem [256];
    logic        clr = 1'b0;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cpu8_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .halted    (halted)
    );

    // Behavioural synchronous memory: one-cycle read, low-byte writes
    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        end else begin
            if (ld_en)  mem[ld_addr] <= ld_data;
            if (mem_we) mem[mem_addr][7:0] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    // Instruction encoders
    function automatic logic [15:0] e_halt();
        return 16'h1000;
    endfunction
    function automatic logic [15:0] e_movi(input logic [2:0] c, input logic [2:0] d, input logic [7:0] v);
        return {1'b1, c, 1'b0, d, v};
    endfunction
    function automatic logic [15:0] e_call(input logic [2:0] c, input logic [7:0] a);
        return {1'b1, c, 4'b1111, a};
    endfunction
    function automatic logic [15:0] e_mov(input logic [2:0] d, input logic [2:0] s);
        return {5'b00011, d, 1'b0, s, 4'b0000};
    endfunction
    function automatic logic [15:0] e_ldp(input logic [2:0] d, input logic [2:0] p);
        return {5'b00101, d, 5'b00000, p};
    endfunction
    function automatic logic [15:0] e_lda(input logic [2:0] d, input logic [7:0] a);
        return {5'b00100, d, a};
    endfunction
    function automatic logic [15:0] e_stp(input logic [2:0] s, input logic [2:0] p);
        return {5'b00111, s, 5'b00000, p};
    endfunction
    function automatic logic [15:0] e_sta(input logic [2:0] s, input logic [7:0] a);
        return {5'b00110, s, a};
    endfunction
    function automatic logic [15:0] e_alu(input logic [2:0] op, input logic [2:0] d, input logic i,
                                          input logic [2:0] x, input logic r, input logic [2:0] y);
        return {2'b01, op, d, i, x, r, y};
    endfunction
    function automatic logic [15:0] e_un(input logic [1:0] u, input logic [2:0] d,
                                         input logic [2:0] s, input logic r);
        return {5'b01111, d, 1'b0, s, r, u, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] w);
        ld_en = 1'b1; ld_addr = a; ld_data = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic prep();
        rst = 1'b1;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Release reset and count edges until halted rises (R2)
    task automatic run_prog(input string req, input int n_instr);
        int cnt;
        @(negedge clk);
        rst = 1'b0;
        cnt = 0;
        while (!halted && cnt < 2000) begin
            @(posedge clk);
            #1;
            cnt++;
        end
        chk(req, cnt, 3 * n_instr);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 mem_rd", {31'd0, mem_rd}, 1);
        chk("R1 mem_addr", {24'd0, mem_addr}, 0);
        chk("R1 mem_we", {31'd0, mem_we}, 0);
        chk("R1 halted", {31'd0, halted}, 0);
    endtask

    task automatic t_nop_halt();
        int busy;
        prep();
        put(8'h00, e_movi(3'b000, G0, 8'h05));
        put(8'h01, 16'h07FF);
        put(8'h02, e_sta(G0, 8'hD0));
        put(8'h03, e_halt());
        put(8'h04, e_sta(G0, 8'hD1));
        run_prog("R2 R3 halt cycles", 4);
        chk("R4 nop keeps G0", {16'd0, mem[8'hD0]}, 32'h0005);
        busy = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_rd || mem_we) busy++;
        end
        chk("R3 quiet after halt", busy, 0);
        chk("R3 halted sticky", {31'd0, halted}, 1);
        chk("R3 next not run", {16'd0, mem[8'hD1]}, 0);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears halt", {31'd0, halted}, 0);
    endtask

    task automatic t_mov_mem();
        prep();
        put(8'hC0, 16'hAB5A);
        put(8'hC1, 16'h1233);
        put(8'hD0, 16'h7700);
        put(8'h00, e_movi(3'b000, P0, 8'hC0));
        put(8'h01, e_ldp(G1, P0));
        put(8'h02, e_mov(G2, G1));
        put(8'h03, e_sta(G2, 8'hD0));
        put(8'h04, e_lda(G3, 8'hC1));
        put(8'h05, e_movi(3'b000, P1, 8'hD1));
        put(8'h06, e_stp(G3, P1));
        put(8'h07, e_mov(G0, PCR));
        put(8'h08, e_sta(G0, 8'hD2));
        put(8'h09, e_halt());
        run_prog("R2 mem prog cycles", 10);
        chk("R7 byte lane keeps high", {16'd0, mem[8'hD0]}, 32'h775A);
        chk("R6 absolute load low byte", {16'd0, mem[8'hD1]}, 32'h0033);
        chk("R5 PC read gives next", {16'd0, mem[8'hD2]}, 32'h0008);
    endtask

    task automatic t_movi_cond();
        prep();
        put(8'h00, e_movi(3'b000, G0, 8'h00));
        put(8'h01, e_movi(3'b000, G1, 8'h11));
        put(8'h02, e_alu(3'b011, G0, 1'b1, G0, 1'b0, 3'd0));
        put(8'h03, e_movi(3'b001, G1, 8'h22));
        put(8'h04, e_movi(3'b110, G1, 8'h33));
        put(8'h05, e_movi(3'b111, G1, 8'h44));
        put(8'h06, e_movi(3'b100, G2, 8'h55));
        put(8'h07, e_movi(3'b011, G2, 8'h66));
        put(8'h08, e_sta(G1, 8'hD0));
        put(8'h09, e_sta(G2, 8'hD1));
        put(8'h0A, e_alu(3'b011, G0, 1'b1, G0, 1'b0, 3'd1));
        put(8'h0B, e_movi(3'b101, G3, 8'h77));
        put(8'h0C, e_movi(3'b010, G3, 8'h88));
        put(8'h0D, e_movi(3'b011, G0, 8'h99));
        put(8'h0E, e_sta(G3, 8'hD2));
        put(8'h0F, e_sta(G0, 8'hD3));
        put(8'h10, e_halt());
        run_prog("R2 movi prog cycles", 17);
        chk("R8 Z/NZ/never", {16'd0, mem[8'hD0]}, 32'h0022);
        chk("R8 NC/C", {16'd0, mem[8'hD1]}, 32'h0055);
        chk("R8 S/NS", {16'd0, mem[8'hD2]}, 32'h0077);
        chk("R8 C taken, flag-only sub", {16'd0, mem[8'hD3]}, 32'h0099);
    endtask

    task automatic t_jump_call();
        prep();
        put(8'h00, e_movi(3'b000, G0, 8'h01));
        put(8'h01, e_call(3'b000, 8'h10));
        put(8'h02, e_sta(G0, 8'hD0));
        put(8'h03, e_mov(G1, LNK));
        put(8'h04, e_sta(G1, 8'hD1));
        put(8'h05, e_movi(3'b000, PCR, 8'h08));
        put(8'h06, e_movi(3'b000, G0, 8'hEE));
        put(8'h07, e_sta(G0, 8'hD2));
        put(8'h08, e_alu(3'b011, G0, 1'b1, G0, 1'b0, 3'd2));
        put(8'h09, e_call(3'b001, 8'h20));
        put(8'h0A, e_movi(3'b110, PCR, 8'h0C));
        put(8'h0B, e_halt());
        put(8'h0C, e_mov(G2, LNK));
        put(8'h0D, e_sta(G2, 8'hD3));
        put(8'h0E, e_halt());
        put(8'h10, e_movi(3'b000, G0, 8'h42));
        put(8'h11, e_mov(PCR, LNK));
        put(8'h20, e_movi(3'b000, G0, 8'hBB));
        put(8'h21, e_halt());
        run_prog("R2 R9 branch prog cycles", 14);
        chk("R9 call and return", {16'd0, mem[8'hD0]}, 32'h0042);
        chk("R9 link value", {16'd0, mem[8'hD1]}, 32'h0002);
        chk("R9 jump skips", {16'd0, mem[8'hD2]}, 32'h0000);
        chk("R9 untaken call keeps link", {16'd0, mem[8'hD3]}, 32'h0002);
    endtask

    task automatic t_alu_bin();
        prep();
        put(8'h00, e_movi(3'b000, G0, 8'hF0));
        put(8'h01, e_movi(3'b000, G1, 8'h20));
        put(8'h02, e_alu(3'b001, G2, 1'b0, G0, 1'b1, G1));
        put(8'h03, e_alu(3'b000, G3, 1'b1, G0, 1'b1, 3'd3));
        put(8'h04, e_sta(G2, 8'hD0));
        put(8'h05, e_sta(G3, 8'hD1));
        put(8'h06, e_alu(3'b011, G2, 1'b0, G1, 1'b1, G0));
        put(8'h07, e_alu(3'b010, G3, 1'b1, G0, 1'b1, 3'd1));
        put(8'h08, e_sta(G2, 8'hD2));
        put(8'h09, e_sta(G3, 8'hD3));
        put(8'h0A, e_alu(3'b100, G0, 1'b0, G0, 1'b1, G1));
        put(8'h0B, e_alu(3'b101, G1, 1'b1, G1, 1'b1, 3'd7));
        put(8'h0C, e_alu(3'b110, G2, 1'b0, G0, 1'b1, G1));
        put(8'h0D, e_sta(G0, 8'hD4));
        put(8'h0E, e_sta(G1, 8'hD5));
        put(8'h0F, e_sta(G2, 8'hD6));
        put(8'h10, e_alu(3'b001, G3, 1'b0, G0, 1'b0, G1));
        put(8'h11, e_sta(G3, 8'hD7));
        put(8'h12, e_halt());
        run_prog("R2 alu prog cycles", 19);
        chk("R10 add", {16'd0, mem[8'hD0]}, 32'h0010);
        chk("R10 adc with carry", {16'd0, mem[8'hD1]}, 32'h00F4);
        chk("R10 sub borrow", {16'd0, mem[8'hD2]}, 32'h0030);
        chk("R10 sbc with borrow", {16'd0, mem[8'hD3]}, 32'h00EE);
        chk("R10 and", {16'd0, mem[8'hD4]}, 32'h0020);
        chk("R10 or imm", {16'd0, mem[8'hD5]}, 32'h0027);
        chk("R10 xor", {16'd0, mem[8'hD6]}, 32'h0007);
        chk("R10 r=0 no write", {16'd0, mem[8'hD7]}, 32'h00EE);
    endtask

    task automatic t_alu_un();
        prep();
        put(8'h00, e_movi(3'b000, G0, 8'h81));
        put(8'h01, e_un(2'b00, G1, G0, 1'b1));
        put(8'h02, e_un(2'b01, G2, G0, 1'b1));
        put(8'h03, e_un(2'b10, G3, G0, 1'b1));
        put(8'h04, e_un(2'b11, P0, G1, 1'b1));
        put(8'h05, e_un(2'b11, P1, G1, 1'b1));
        put(8'h06, e_sta(G1, 8'hD0));
        put(8'h07, e_sta(G2, 8'hD1));
        put(8'h08, e_sta(G3, 8'hD2));
        put(8'h09, e_sta(P0, 8'hD3));
        put(8'h0A, e_sta(P1, 8'hD4));
        put(8'h0B, e_halt());
        run_prog("R2 unary prog cycles", 12);
        chk("R11 invert", {16'd0, mem[8'hD0]}, 32'h007E);
        chk("R11 rotate", {16'd0, mem[8'hD1]}, 32'h00C0);
        chk("R11 shift", {16'd0, mem[8'hD2]}, 32'h0040);
        chk("R11 rcr carry in 1", {16'd0, mem[8'hD3]}, 32'h00BF);
        chk("R11 rcr carry in 0", {16'd0, mem[8'hD4]}, 32'h003F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_nop_halt();
        t_mov_mem();
        t_movi_cond();
        t_jump_call();
        t_alu_bin();
        t_alu_un();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule